// File: doc/BRIEF.md
# Bit-Serial Register Bank

This block holds the working registers of a bit-serial stack machine: eight program-visible registers, R0 (top of stack) to R7, and two internal registers, one for a constant and one for a data byte. Each register shifts one bit per clock. It hands one bit to an external routing fabric and takes one bit back from that fabric. The fabric decides where each bit goes. Moving, swapping, pushing or clearing registers therefore takes one full pass of n shifts, where n is 16 or 32 depending on the width mode.

A 3-bit operation code selects, in a single cycle, what each of three groups does. The groups are the top of stack (R0), the next-on-stack (R1), and all remaining registers together. Each group either holds, shifts down or shifts up. One code instead loads an 8-bit value in parallel into the constant or the data register. Every register also keeps a zero flag. The flag is armed to 1 before a pass and drops the first time a 1 bit leaves the register during a shift. After a pass, the flag tells whether the register held zero.

Lane indices on the fabric buses are fixed: bits 0..7 are R0..R7, bit 8 is the constant register and bit 9 is the data register.

Top module: `serial_regbank`

## Requirements
- R1: While rst_n is low, all ten registers are cleared to zero and all zero flags are set to 1. After reset, each register reads back as zero.
- R2: The operation code maps to group actions as follows, written as R0/R1/others. 0 is hold/hold/hold. 1 is hold/hold/hold and also loads. 2 is up/down/down. 3 is hold/up/up. 4 is down/down/down. 5 is down/down/hold. 6 is hold/down/down. 7 is up/up/hold. The "others" group is R2..R7 plus the constant and data registers.
- R3: A down shift moves every bit one place toward the LSB. The register presents its LSB on its fabric output and takes its fabric input bit into its top bit (bit n-1).
- R4: An up shift moves every bit one place toward the top bit. The register presents bit n-1 on its fabric output and takes its fabric input bit into its LSB.
- R5: A register that holds keeps its value, and its fabric output shows its LSB.
- R6: wide_i=1 gives a 32-bit length and wide_i=0 gives a 16-bit length. In 16-bit mode, bits 31..16 of every register are forced to zero on each clock, so they stay zero after a return to 32-bit mode.
- R7: With operation code 1, ld_cst_i loads the zero-extended ld_val_i into the constant register and ld_dat_i loads it into the data register. R0..R7 are left unchanged.
- R8: arm_i sets every zero flag to 1 on the next clock. After that, a flag clears the first time its register shifts (up or down) while presenting a 1 on its output. It stays cleared until the next arm. Holding never changes a flag.
- R9: n down shifts, or n up shifts, with each output routed back to the same register's input, leave the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Group operation code (R2) |
| wide_i | input | 1 | 1 = 32-bit length, 0 = 16-bit length |
| fab_in_i | input | 10 | Serial input bit per register, from the routing fabric |
| fab_out_o | output | 10 | Serial output bit per register, to the routing fabric |
| ld_cst_i | input | 1 | Load enable for the constant register (with code 1) |
| ld_dat_i | input | 1 | Load enable for the data register (with code 1) |
| ld_val_i | input | 8 | Parallel load value |
| arm_i | input | 1 | Set all zero flags to 1 |
| zf_o | output | 10 | Per-register zero flag |

## Verification
The register contents can only be seen by rotating them out serially. A single corrupted bit therefore stays hidden until the pass that brings it to the output, which can be up to n cycles later. A wrong group decode or a wrong shift direction shows up on the very next clock, as a mismatched output bit on the affected lanes. A bad mask in 16-bit mode only becomes visible when the register is read back in 32-bit mode. A zero flag that fails to stick, or that clears during a hold, differs from the expected value in the cycle right after the offending edge.

// File: rtl/srb_pkg.sv
// Shared types for the bit-serial register bank.
// Assumes: three register groups (top, next, others), three actions each.
package srb_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DN   = 2'd1,
        ACT_UP   = 2'd2
    } act_e;

    // Operation codes; encoding is part of the external contract (R2)
    typedef enum logic [2:0] {
        OP_HHH  = 3'd0,
        OP_LOAD = 3'd1,
        OP_UDD  = 3'd2,
        OP_HUU  = 3'd3,
        OP_DDD  = 3'd4,
        OP_DDH  = 3'd5,
        OP_HDD  = 3'd6,
        OP_UUH  = 3'd7
    } op_e;

    typedef struct packed {
        act_e tos;
        act_e nos;
        act_e oth;
        logic ld;
    } ctl_t;

endpackage

// File: rtl/srb_op_decode.sv
// Expands the 3-bit operation code into per-group actions plus a load strobe.
// Assumes: purely combinational; the caller qualifies the load strobe.
module srb_op_decode
    import srb_pkg::*;
(
    input  logic [2:0] op_i,
    output ctl_t       ctl_o
);

    // Fixed table of group actions
    always_comb begin
        ctl_o = '{tos: ACT_HOLD, nos: ACT_HOLD, oth: ACT_HOLD, ld: 1'b0};
        unique case (op_e'(op_i))
            OP_HHH:  ;
            OP_LOAD: ctl_o.ld = 1'b1;
            OP_UDD:  ctl_o = '{tos: ACT_UP,   nos: ACT_DN,   oth: ACT_DN,   ld: 1'b0};
            OP_HUU:  ctl_o = '{tos: ACT_HOLD, nos: ACT_UP,   oth: ACT_UP,   ld: 1'b0};
            OP_DDD:  ctl_o = '{tos: ACT_DN,   nos: ACT_DN,   oth: ACT_DN,   ld: 1'b0};
            OP_DDH:  ctl_o = '{tos: ACT_DN,   nos: ACT_DN,   oth: ACT_HOLD, ld: 1'b0};
            OP_HDD:  ctl_o = '{tos: ACT_HOLD, nos: ACT_DN,   oth: ACT_DN,   ld: 1'b0};
            OP_UUH:  ctl_o = '{tos: ACT_UP,   nos: ACT_UP,   oth: ACT_HOLD, ld: 1'b0};
            default: ;
        endcase
    end

endmodule

// File: rtl/srb_lane.sv
// One serial register with its zero flag.
// Assumes: W is even and at least LW. In narrow mode only the lower W/2 bits
// are live; the upper half is cleared every clock.
module srb_lane
    import srb_pkg::*;
#(
    parameter int W  = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act_i,
    input  logic          wide_i,
    input  logic          sin_i,
    input  logic          ld_i,
    input  logic [LW-1:0] ld_val_i,
    input  logic          arm_i,
    output logic          sout_o,
    output logic          zf_o
);

    localparam int HALF = W / 2;

    logic [W-1:0] r_q, r_nxt, mask;
    logic         zf_q;

    // Length mask for the current mode
    always_comb mask = wide_i ? {W{1'b1}} : {{(W-HALF){1'b0}}, {HALF{1'b1}}};

    // Output bit: top live bit when shifting up, LSB otherwise
    always_comb sout_o = (act_i == ACT_UP) ? (wide_i ? r_q[W-1] : r_q[HALF-1]) : r_q[0];

    // Next register value from action, load and length mask
    always_comb begin
        r_nxt = r_q;
        unique case (act_i)
            ACT_DN: begin
                r_nxt = r_q >> 1;
                if (wide_i) r_nxt[W-1] = sin_i;
                else        r_nxt[HALF-1] = sin_i;
            end
            ACT_UP:  r_nxt = {r_q[W-2:0], sin_i};
            default: ;
        endcase
        if (ld_i) r_nxt = {{(W-LW){1'b0}}, ld_val_i};
        r_nxt = r_nxt & mask;
    end

    // Register state
    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_nxt;
    end

    // Zero flag: armed to 1, cleared sticky by a 1 leaving during a shift
    always_ff @(posedge clk) begin
        if (!rst_n || arm_i)                        zf_q <= 1'b1;
        else if (act_i != ACT_HOLD && sout_o)       zf_q <= 1'b0;
    end

    assign zf_o = zf_q;

endmodule

// File: rtl/serial_regbank.sv
// Bank of program and internal serial registers driven by one operation code.
// Assumes: lanes 0..N_PROG-1 are program registers, lane N_PROG is the
// constant register, lane N_PROG+1 the data register.
module serial_regbank
    import srb_pkg::*;
#(
    parameter int N_PROG = 8,
    parameter int W      = 32,
    parameter int LW     = 8,
    localparam int N_LANE = N_PROG + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [N_LANE-1:0] fab_in_i,
    output logic [N_LANE-1:0] fab_out_o,
    input  logic              ld_cst_i,
    input  logic              ld_dat_i,
    input  logic [LW-1:0]     ld_val_i,
    input  logic              arm_i,
    output logic [N_LANE-1:0] zf_o
);

    localparam int IDX_CST = N_PROG;
    localparam int IDX_DAT = N_PROG + 1;

    ctl_t ctl;

    srb_op_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    // One lane per register; group and load select by position
    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        act_e lane_act;
        logic lane_ld;

        if (i == 0) begin : g_tos
            assign lane_act = ctl.tos;
        end else if (i == 1) begin : g_nos
            assign lane_act = ctl.nos;
        end else begin : g_oth
            assign lane_act = ctl.oth;
        end

        if (i == IDX_CST) begin : g_ldc
            assign lane_ld = ctl.ld & ld_cst_i;
        end else if (i == IDX_DAT) begin : g_ldd
            assign lane_ld = ctl.ld & ld_dat_i;
        end else begin : g_nold
            assign lane_ld = 1'b0;
        end

        srb_lane #(.W(W), .LW(LW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (lane_act),
            .wide_i   (wide_i),
            .sin_i    (fab_in_i[i]),
            .ld_i     (lane_ld),
            .ld_val_i (ld_val_i),
            .arm_i    (arm_i),
            .sout_o   (fab_out_o[i]),
            .zf_o     (zf_o[i])
        );
    end

endmodule

// File: rtl/srb_chk.sv
// Port-level properties of the serial register bank, attached by bind.
// Assumes: the lane order of the top module (constant lane at N_LANE-2).
module srb_chk #(
    parameter int N_LANE = 10,
    parameter int LW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              arm_i,
    input logic              ld_cst_i,
    input logic [LW-1:0]     ld_val_i,
    input logic [N_LANE-1:0] fab_out_o,
    input logic [N_LANE-1:0] zf_o
);

    // R8
    zf_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (zf_o == {N_LANE{1'b1}}));

    // R8
    zf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> ((zf_o & ~$past(zf_o)) == '0));

    // R8
    zf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && op_i == 3'd4 && fab_out_o[0]) |=> !zf_o[0]);

    // R5
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0) |=> (op_i != 3'd0 || $stable(fab_out_o)));

    // R7
    load_cst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && ld_cst_i) |=> (op_i != 3'd4 || fab_out_o[N_LANE-2] == $past(ld_val_i[0])));

endmodule

bind serial_regbank srb_chk #(.N_LANE(N_LANE), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .arm_i     (arm_i),
    .ld_cst_i  (ld_cst_i),
    .ld_val_i  (ld_val_i),
    .fab_out_o (fab_out_o),
    .zf_o      (zf_o)
);

// File: tb/serial_regbank_tb_top.sv
// Scoreboard bench: the driver predicts every cycle's outputs from a
// requirement-level model; the monitor compares them with the design.
module serial_regbank_tb_top;

    localparam int NL = 10;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    op;
    logic          wide;
    logic [NL-1:0] fin;
    logic [NL-1:0] fout;
    logic          ldc, ldd, arm;
    logic [7:0]    lval;
    logic [NL-1:0] zf;

    always #5 clk = ~clk;

    serial_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .wide_i(wide),
        .fab_in_i(fin), .fab_out_o(fout), .ld_cst_i(ldc), .ld_dat_i(ldd),
        .ld_val_i(lval), .arm_i(arm), .zf_o(zf)
    );

    typedef struct {
        logic [NL-1:0] out;
        logic [NL-1:0] zfl;
        string         rq;
    } item_t;

    item_t         sbq[$];
    event          mon_ev;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [W-1:0]  m [NL];
    logic [NL-1:0] mzf;

    // Group action per R2: 0 hold, 1 down, 2 up
    function automatic int act(input logic [2:0] o, input int i);
        int g = (i == 0) ? 0 : ((i == 1) ? 1 : 2);
        case (o)
            3'd2: return (g == 0) ? 2 : 1;
            3'd3: return (g == 0) ? 0 : 2;
            3'd4: return 1;
            3'd5: return (g == 2) ? 0 : 1;
            3'd6: return (g == 0) ? 0 : 1;
            3'd7: return (g == 2) ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic mout(input logic [2:0] o, input int i);
        int top = wide ? W - 1 : W / 2 - 1;
        return (act(o, i) == 2) ? m[i][top] : m[i][0];
    endfunction

    // Monitor: pops the expected item and compares at the sample point
    always @(mon_ev) begin
        item_t it;
        it = sbq.pop_front();
        n_chk++;
        if (fout !== it.out || zf !== it.zfl) begin
            n_bad++;
            $display("FAIL %s: out=%h exp=%h zf=%h exp=%h", it.rq, fout, it.out, zf, it.zfl);
        end
    end

    // Driver: one cycle; lanes in omask take oval, the rest loop back
    task automatic step(input logic [2:0] o, input logic [NL-1:0] omask,
                        input logic [NL-1:0] oval, input logic a, input logic lc,
                        input logic ld, input logic [7:0] lv, input string rq,
                        output logic [NL-1:0] seen);
        item_t it;
        logic [NL-1:0] eo;
        logic [W-1:0] nv;
        logic [W-1:0] msk;
        @(negedge clk);
        for (int i = 0; i < NL; i++) eo[i] = mout(o, i);
        op = o; arm = a; ldc = lc; ldd = ld; lval = lv;
        fin = (eo & ~omask) | (oval & omask);
        it.out = eo; it.zfl = mzf; it.rq = rq;
        sbq.push_back(it);
        #1;
        -> mon_ev;
        seen = fout;
        @(posedge clk);
        msk = wide ? '1 : 32'h0000_FFFF;
        for (int i = 0; i < NL; i++) begin
            nv = m[i];
            if (act(o, i) == 1) begin
                nv = m[i] >> 1;
                if (wide) nv[W-1] = fin[i]; else nv[W/2-1] = fin[i];
            end else if (act(o, i) == 2) begin
                nv = {m[i][W-2:0], fin[i]};
            end
            if (o == 3'd1 && ((i == 8 && lc) || (i == 9 && ld))) nv = {24'h0, lv};
            if (a) mzf[i] = 1'b1;
            else if (act(o, i) != 0 && eo[i]) mzf[i] = 1'b0;
            m[i] = nv & msk;
        end
    endtask

    task automatic check(input string rq, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%h exp=%h", rq, got, exp);
        end
    endtask

    // Read one lane by a self-looped down rotation of len cycles (R9)
    task automatic rd(input int idx, input int len, input string rq, output logic [W-1:0] v);
        logic [NL-1:0] s;
        v = '0;
        for (int k = 0; k < len; k++) begin
            step(3'd4, '0, '0, 1'b0, 1'b0, 1'b0, 8'h0, rq, s);
            v[k] = s[idx];
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got=timeout exp=completion");
        summary();
    end

    initial begin
        logic [W-1:0] v;
        logic [NL-1:0] s;
        logic [W-1:0] pat;
        rst_n = 1'b0; op = 3'd0; wide = 1'b1; fin = '0;
        ldc = 1'b0; ldd = 1'b0; lval = 8'h0; arm = 1'b0;
        for (int i = 0; i < NL; i++) m[i] = '0;
        mzf = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 zero flags after reset", {22'h0, zf}, {22'h0, {NL{1'b1}}});
        rd(0, 32, "R1", v);
        check("R1 R0 after reset", v, 32'h0);

        // R7: parallel loads
        step(3'd1, '0, '0, 1'b0, 1'b1, 1'b0, 8'hA5, "R7", s);
        step(3'd1, '0, '0, 1'b0, 1'b0, 1'b1, 8'h3C, "R7", s);
        rd(8, 32, "R7", v); check("R7 constant register", v, 32'h0000_00A5);
        rd(9, 32, "R7", v); check("R7 data register", v, 32'h0000_003C);
        rd(0, 32, "R7", v); check("R7 R0 untouched by load", v, 32'h0);

        // R3: fill R0 by down shifts, LSB first
        pat = 32'h1234_5678;
        for (int k = 0; k < 32; k++)
            step(3'd4, 10'h001, {9'h0, pat[k]}, 1'b0, 1'b0, 1'b0, 8'h0, "R3", s);
        rd(0, 32, "R3", v); check("R3 R0 down-shift fill", v, 32'h1234_5678);
        rd(0, 32, "R9", v); check("R9 rotation identity", v, 32'h1234_5678);

        // R4: fill R1 by up shifts, MSB first; R0 rotates up on itself
        pat = 32'hCAFE_F00D;
        for (int k = 31; k >= 0; k--)
            step(3'd7, 10'h002, {8'h0, pat[k], 1'b0}, 1'b0, 1'b0, 1'b0, 8'h0, "R4", s);
        rd(1, 32, "R4", v); check("R4 R1 up-shift fill", v, 32'hCAFE_F00D);
        rd(0, 32, "R9", v); check("R9 up rotation identity", v, 32'h1234_5678);

        // R5: hold with all fabric inputs high
        for (int k = 0; k < 5; k++)
            step(3'd0, '1, '1, 1'b0, 1'b0, 1'b0, 8'h0, "R5", s);
        rd(0, 32, "R5", v); check("R5 R0 held", v, 32'h1234_5678);
        rd(1, 32, "R5", v); check("R5 R1 held", v, 32'hCAFE_F00D);

        // R2: code 6 clears NOS/others with zeros, TOS holds
        for (int k = 0; k < 32; k++)
            step(3'd6, '1, '0, 1'b0, 1'b0, 1'b0, 8'h0, "R2", s);
        rd(0, 32, "R2", v); check("R2 code6 TOS holds", v, 32'h1234_5678);
        rd(1, 32, "R2", v); check("R2 code6 NOS cleared", v, 32'h0);
        rd(8, 32, "R2", v); check("R2 code6 constant cleared", v, 32'h0);
        // R2: code 2 moves TOS up with zeros in
        for (int k = 0; k < 4; k++)
            step(3'd2, 10'h001, '0, 1'b0, 1'b0, 1'b0, 8'h0, "R2", s);
        rd(0, 32, "R2", v); check("R2 code2 TOS up by four", v, 32'h2345_6780);

        // R8: arm, then one pass clears only nonzero lanes
        step(3'd0, '0, '0, 1'b1, 1'b0, 1'b0, 8'h0, "R8", s);
        #1; check("R8 armed flags", {22'h0, zf}, {22'h0, {NL{1'b1}}});
        rd(0, 32, "R8", v);
        #1; check("R8 flags after pass", {22'h0, zf}, {22'h0, 10'b1111111110});
        step(3'd0, '1, '1, 1'b0, 1'b0, 1'b0, 8'h0, "R8 hold", s);
        #1; check("R8 hold keeps flags", {22'h0, zf}, {22'h0, 10'b1111111110});

        // R6: narrow mode masks the upper half
        wide = 1'b0;
        step(3'd0, '0, '0, 1'b0, 1'b0, 1'b0, 8'h0, "R6", s);
        rd(0, 16, "R6", v); check("R6 narrow R0", v, 32'h0000_6780);
        step(3'd1, '0, '0, 1'b0, 1'b1, 1'b0, 8'h81, "R6", s);
        for (int k = 0; k < 16; k++)
            step(3'd3, '0, '0, 1'b0, 1'b0, 1'b0, 8'h0, "R6 narrow up", s);
        rd(8, 16, "R6", v); check("R6 narrow up rotation", v, 32'h0000_0081);
        wide = 1'b1;
        rd(0, 32, "R6", v); check("R6 upper half stays zero", v, 32'h0000_6780);

        summary();
    end

endmodule